// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

The block is a watchdog that runs from a slow, always-on clock. Two counters in series form the time base. The first is a fixed divider of `BASE_EXP` stages. The second is a 10-stage prescaler that counts the divider's carries. A 3-bit select code picks one of eight tap points on this chain, and that tap sets the timeout. Firmware must clear the watchdog before the selected period runs out. The clear can come from a clear strobe or from a halt strobe. If the period runs out first, the block asks for a reset.

A 5-bit key field guards the watchdog. Only two complementary patterns are accepted, and both leave the timer running. Any other value is treated as a reset command. After a short delay the block issues a full device reset, sets a sticky flag that records the cause, and reloads the key with its power-up pattern.

The reset that a timeout produces depends on the core's state. When the core is running, a timeout produces a full device reset. When the core is sleeping or idle, it produces only a partial reset of the program counter and stack pointer. In both cases a timeout status flag is raised.

Top module: `key_wdt`

## Requirements
- R1: After power-on reset the key field reads 01010b and the select field reads 0. The timeout flag, the key-reset flag and both reset outputs are 0.
- R2: Select codes 0..7 give periods of 2^(B), 2^(B+2), 2^(B+4), 2^(B+6), 2^(B+7), 2^(B+8), 2^(B+9) and 2^(B+10) clock cycles, where B = `BASE_EXP` (default 8, so 2^8 up to 2^18). The period is measured from the clock edge that clears the counter to the edge that raises the reset output.
- R3: Key values 01010b and 10101b are accepted. They read back unchanged and produce no reset and no key-reset flag.
- R4: When any other key value is written, `rst_full_o` rises exactly 2 clock edges after the write edge. On that same edge the key-reset flag is set, the key reloads to 01010b and the counter restarts from zero.
- R5: A register write with `wr_flag_i`=0 clears the key-reset flag. A write with `wr_flag_i`=1 leaves it unchanged. Only an illegal key sets it.
- R6: A pulse on `clr_wdt_i` restarts the counter and clears the timeout flag. Pulsing it more often than the period prevents every reset.
- R7: A pulse on `halt_i` has the same effect as `clr_wdt_i`: it restarts the counter and clears the timeout flag.
- R8: With `sleep_i`=0, a timeout pulses `rst_full_o`, leaves `rst_part_o` low and sets `timeout_o`.
- R9: With `sleep_i`=1, a timeout pulses `rst_part_o`, leaves `rst_full_o` low and sets `timeout_o`.
- R10: A newly written select code takes effect only at the next counter restart (a clear, a halt, a timeout or a key reset). A timing run already under way keeps its old period.
- R11: Each reset output is a one-cycle pulse. After a timeout the counter restarts on its own, so the next timeout follows one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow low-speed clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Register write strobe; loads key, select and flag-write bit |
| wr_key_i | input | KEY_W | Key value to write |
| wr_sel_i | input | 3 | Period select code to write |
| wr_flag_i | input | 1 | Flag write bit: 0 clears the key-reset flag, 1 leaves it |
| clr_wdt_i | input | 1 | Clear-watchdog strobe |
| halt_i | input | 1 | Halt strobe; clears like `clr_wdt_i` |
| sleep_i | input | 1 | Core is in sleep or idle mode |
| rst_full_o | output | 1 | Full device reset request pulse |
| rst_part_o | output | 1 | Partial (program counter and stack pointer) reset pulse |
| timeout_o | output | 1 | Timeout status flag |
| key_rst_flag_o | output | 1 | Sticky flag: last reset was caused by an illegal key |
| ctrl_key_o | output | KEY_W | Key field readback |
| ctrl_sel_o | output | 3 | Select field readback |

## Verification
Every select code is measured once with `sleep_i` low and once with it high. The run-mode pass shows that each tap is placed correctly. The sleep pass shows that the mode steers the pulse to the correct reset output. Three illegal keys are tried: all zeros, all ones and a single-bit miss from a legal key. These show that only the exact two patterns are accepted, that the delay is exactly two edges, and that the counter restarts from the key reset. Periodic clear and halt strobes with a gap shorter than the period must never produce a reset. A select change from the longest to the shortest period mid-run separates "takes effect at the next restart" from "takes effect at once".

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned PRE_W = 10;

  // prescaler bits consumed above the fixed divider for a select code
  function automatic int unsigned tap_ofs(input int unsigned code);
    return (code < 4) ? 2 * code : code + 3;
  endfunction
endpackage

// File: rtl/wdt_key_ctl.sv
module wdt_key_ctl #(
  parameter int unsigned   KEY_W = 5,
  parameter logic [KEY_W-1:0] KEY_A = 5'b01010,
  parameter logic [KEY_W-1:0] KEY_B = 5'b10101,
  parameter int unsigned   DLY   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  logic             wr_flag_i,
  output logic [KEY_W-1:0] key_o,
  output logic             fire_o,
  output logic             flag_o
);
  localparam int unsigned DLY_W = (DLY < 2) ? 1 : $clog2(DLY);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DLY - 1);

  logic [KEY_W-1:0] key_q;
  logic [DLY_W-1:0] bad_q;
  logic             flag_q;
  logic             legal;

  assign legal  = (key_q == KEY_A) || (key_q == KEY_B);
  assign fire_o = !legal && (bad_q == DLY_LAST);
  assign key_o  = key_q;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= KEY_A;
      bad_q <= '0;
    end else if (fire_o) begin
      key_q <= KEY_A;
      bad_q <= '0;
    end else begin
      if (wr_en_i) key_q <= wr_key_i;
      bad_q <= legal ? '0 : bad_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    flag_q <= 1'b0;
    else if (fire_o)                flag_q <= 1'b1;
    else if (wr_en_i && !wr_flag_i) flag_q <= 1'b0;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             term_o
);
  localparam int unsigned N_TAP = 1 << SEL_W;

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q;
  logic             div_full;
  logic [N_TAP-1:0] tap;

  assign div_full = &div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (clr_i) begin
      div_q <= '0;
      pre_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      if (div_full) pre_q <= pre_q + 1'b1;
    end
  end

  for (genvar k = 0; k < N_TAP; k++) begin : g_tap
    localparam int unsigned OFS = tap_ofs(k);
    if (OFS == 0) begin : g_div
      assign tap[k] = div_full;
    end else begin : g_pre
      assign tap[k] = div_full & (&pre_q[OFS-1:0]);
    end
  end

  assign term_o = tap[sel_i];
endmodule

// File: rtl/key_wdt.sv
module key_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned      BASE_EXP = 8,
  parameter int unsigned      KEY_W    = 5,
  parameter logic [KEY_W-1:0] KEY_A    = 5'b01010,
  parameter logic [KEY_W-1:0] KEY_B    = 5'b10101,
  parameter int unsigned      KEY_DLY  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  logic [2:0]       wr_sel_i,
  input  logic             wr_flag_i,
  input  logic             clr_wdt_i,
  input  logic             halt_i,
  input  logic             sleep_i,
  output logic             rst_full_o,
  output logic             rst_part_o,
  output logic             timeout_o,
  output logic             key_rst_flag_o,
  output logic [KEY_W-1:0] ctrl_key_o,
  output logic [2:0]       ctrl_sel_o
);
  logic [SEL_W-1:0] sel_q, sel_act_q;
  logic             fire, term, clr_sw, hit, cnt_clr;
  logic             full_q, part_q, tmo_q;

  wdt_key_ctl #(
    .KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B), .DLY(KEY_DLY)
  ) u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_key_i (wr_key_i),
    .wr_flag_i(wr_flag_i),
    .key_o    (ctrl_key_o),
    .fire_o   (fire),
    .flag_o   (key_rst_flag_o)
  );

  wdt_counter #(.DIV_W(BASE_EXP)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .sel_i (sel_act_q),
    .term_o(term)
  );

  assign clr_sw  = clr_wdt_i | halt_i;
  // a clear or key reset on the terminal edge wins over the timeout
  assign hit     = term & ~clr_sw & ~fire;
  assign cnt_clr = clr_sw | fire | hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= '0;
      sel_act_q <= '0;
    end else begin
      if (wr_en_i) sel_q <= wr_sel_i;
      if (cnt_clr) sel_act_q <= sel_q; // period change only at a restart
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      part_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      full_q <= (hit & ~sleep_i) | fire;
      part_q <= hit & sleep_i;
      if (hit)         tmo_q <= 1'b1;
      else if (clr_sw) tmo_q <= 1'b0;
    end
  end

  assign rst_full_o = full_q;
  assign rst_part_o = part_q;
  assign timeout_o  = tmo_q;
  assign ctrl_sel_o = sel_q;
endmodule

// File: rtl/key_wdt_chk.sv
module key_wdt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic wr_flag_i,
  input logic clr_wdt_i,
  input logic halt_i,
  input logic rst_full_o,
  input logic rst_part_o,
  input logic timeout_o,
  input logic key_rst_flag_o
);
  p_full_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_full_o |=> !rst_full_o);
  p_part_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_part_o |=> !rst_part_o);
  p_reset_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_full_o && rst_part_o));
  p_part_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_part_o |-> timeout_o);
  p_clr_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wdt_i |=> !timeout_o);
  p_halt_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !timeout_o);
  p_flag_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(key_rst_flag_o) |-> rst_full_o);
  p_flag_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_rst_flag_o && !(wr_en_i && !wr_flag_i)) |=> key_rst_flag_o);
endmodule

bind key_wdt key_wdt_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_flag_i     (wr_flag_i),
  .clr_wdt_i     (clr_wdt_i),
  .halt_i        (halt_i),
  .rst_full_o    (rst_full_o),
  .rst_part_o    (rst_part_o),
  .timeout_o     (timeout_o),
  .key_rst_flag_o(key_rst_flag_o)
);

// File: tb/key_wdt_tb_top.sv
module key_wdt_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned BASE       = 2;
  localparam logic [4:0]  KA         = 5'b01010;
  localparam logic [4:0]  KB         = 5'b10101;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, wr_flag_i = 1'b1;
  logic [4:0] wr_key_i = KA;
  logic [2:0] wr_sel_i = '0;
  logic       clr_wdt_i = 1'b0, halt_i = 1'b0, sleep_i = 1'b0;
  logic       rst_full_o, rst_part_o, timeout_o, key_rst_flag_o;
  logic [4:0] ctrl_key_o;
  logic [2:0] ctrl_sel_o;

  int n_chk = 0, n_err = 0, cyc = 0;

  key_wdt #(.BASE_EXP(BASE)) dut_i (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  function automatic int per(input int c);
    return 1 << (BASE + ((c < 4) ? 2 * c : c + 3));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] k, input logic [2:0] s, input logic f);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_key_i = k; wr_sel_i = s; wr_flag_i = f;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_flag_i = 1'b1;
  endtask

  task automatic pulse_clr();
    @(negedge clk_i); clr_wdt_i = 1'b1;
    @(negedge clk_i); clr_wdt_i = 1'b0;
  endtask

  // count edges from a restart until a reset pulse appears
  task automatic wait_pulse(input int lim, output int n, output bit f, output bit p);
    n = 0; f = 0; p = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk_i); n++;
      if (rst_full_o || rst_part_o) begin
        f = rst_full_o; p = rst_part_o;
        break;
      end
    end
  endtask

  task automatic measure(input int c, input bit slp, input string tag);
    int n; bit f, p;
    sleep_i = slp;
    pulse_clr();
    wait_pulse(per(c) + 8, n, f, p);
    chk(n == per(c), {tag, " R2 period"}, n, per(c));
    if (slp) chk(p && !f, "R9 partial only", {f, p}, 1);
    else     chk(f && !p, "R8 full only", {f, p}, 2);
    chk(timeout_o == 1'b1, "R8 timeout flag set", timeout_o, 1);
    @(negedge clk_i);
    chk(!rst_full_o && !rst_part_o, "R11 single pulse", {rst_full_o, rst_part_o}, 0);
    pulse_clr();
    chk(timeout_o == 1'b0, "R6 clear drops timeout", timeout_o, 0);
    sleep_i = 1'b0;
  endtask

  task automatic bad_key(input logic [4:0] k);
    int n; bit f, p;
    wr(KA, 3, 1'b1);
    pulse_clr();
    @(negedge clk_i); wr_en_i = 1'b1; wr_key_i = k;
    @(negedge clk_i); wr_en_i = 1'b0;
    chk(!rst_full_o, "R4 no reset at write", rst_full_o, 0);
    @(negedge clk_i);
    chk(!rst_full_o, "R4 no reset after 1", rst_full_o, 0);
    @(negedge clk_i);
    chk(rst_full_o && !rst_part_o, "R4 reset after 2", rst_full_o, 1);
    chk(key_rst_flag_o, "R4 flag set", key_rst_flag_o, 1);
    chk(ctrl_key_o == KA, "R4 key reload", ctrl_key_o, KA);
    wait_pulse(per(3) + 8, n, f, p);
    chk(n == per(3), "R4 counter restart", n, per(3));
  endtask

  initial begin
    int n, cnt; bit f, p;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ctrl_key_o == KA, "R1 key", ctrl_key_o, KA);
    chk(ctrl_sel_o == 0, "R1 sel", ctrl_sel_o, 0);
    chk(!timeout_o && !key_rst_flag_o, "R1 flags", {timeout_o, key_rst_flag_o}, 0);
    chk(!rst_full_o && !rst_part_o, "R1 resets", {rst_full_o, rst_part_o}, 0);

    for (int c = 0; c < 8; c++) begin
      wr(c[0] ? KB : KA, 3'(c), 1'b1);
      chk(ctrl_sel_o == 3'(c), "R2 sel readback", ctrl_sel_o, c);
      measure(c, 1'b0, "R8");
    end
    for (int c = 0; c < 8; c++) begin
      wr(KA, 3'(c), 1'b1);
      measure(c, 1'b1, "R9");
    end

    // R3 legal keys
    wr(KA, 7, 1'b1); pulse_clr();
    wr(KB, 7, 1'b1);
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i); cnt += rst_full_o;
    end
    chk(ctrl_key_o == KB && cnt == 0 && !key_rst_flag_o, "R3 key B accepted", cnt, 0);
    wr(KA, 7, 1'b1);
    chk(ctrl_key_o == KA, "R3 key A readback", ctrl_key_o, KA);

    // R6 periodic clear, R7 periodic halt
    wr(KA, 1, 1'b1); pulse_clr();
    cnt = 0;
    for (int r = 0; r < 20; r++) begin
      for (int i = 0; i < 10; i++) begin
        @(negedge clk_i); cnt += rst_full_o + rst_part_o;
      end
      clr_wdt_i = 1'b1; @(negedge clk_i); clr_wdt_i = 1'b0;
    end
    chk(cnt == 0, "R6 clear holds off", cnt, 0);
    cnt = 0;
    for (int r = 0; r < 20; r++) begin
      for (int i = 0; i < 10; i++) begin
        @(negedge clk_i); cnt += rst_full_o + rst_part_o;
      end
      halt_i = 1'b1; @(negedge clk_i); halt_i = 1'b0;
    end
    chk(cnt == 0, "R7 halt holds off", cnt, 0);
    wait_pulse(per(1) + 8, n, f, p);
    chk(timeout_o, "R7 timeout before halt", timeout_o, 1);
    halt_i = 1'b1; @(negedge clk_i); halt_i = 1'b0;
    chk(!timeout_o, "R7 halt drops timeout", timeout_o, 0);

    // R10 select change mid-run
    wr(KA, 7, 1'b1); pulse_clr();
    n = 0;
    for (int i = 0; i < per(7) + 8; i++) begin
      @(negedge clk_i); n++;
      if (n == 10) begin wr_en_i = 1'b1; wr_sel_i = 3'd0; end
      if (n == 11) wr_en_i = 1'b0;
      if (rst_full_o) break;
    end
    chk(n == per(7), "R10 old period kept", n, per(7));
    wait_pulse(per(7), n, f, p);
    chk(n == per(0) && f, "R10 R11 new period after restart", n, per(0));

    // R4 illegal keys
    bad_key(5'b00000);
    bad_key(5'b11111);
    bad_key(5'b01011);

    // R5 sticky flag
    wr(KA, 7, 1'b1);
    chk(key_rst_flag_o, "R5 write 1 keeps flag", key_rst_flag_o, 1);
    wr(KA, 7, 1'b0);
    chk(!key_rst_flag_o, "R5 write 0 clears flag", key_rst_flag_o, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule